// File: doc/BRIEF.md
# Configuration Code Settling Filter

This block sits between an upstream converter that produces a 4-bit configuration code once per master clock cycle and the logic that uses that code. The raw code can wander while its source settles. The block passes a new value through only after that value has held steady long enough. The hold time depends on the value itself: a candidate code `k` must be seen on 16 × (k + 6) consecutive valid samples. Code 0 therefore needs 96 samples and code 15 needs 336.

When a candidate qualifies, the accepted code jumps straight from its old value to the new one, and a one-cycle update strobe marks the change. An initial-valid flag reports that a first code has been accepted since reset. Downstream logic uses this flag to hold off start-up until a trustworthy code exists. Monitoring never stops, so a change that settles later in operation is picked up in the same way.

Top module: `code_settle_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `acceptedCode` is 0, `initValid` is 0 and `updateStrobe` is 0.
- R2: A raw code `k` that differs from the accepted value, or that arrives before any code has been accepted, becomes `acceptedCode` on the clock edge that samples its 16 × (k + 6)-th consecutive valid occurrence, and not on any earlier edge.
- R3: Until that edge, `acceptedCode` keeps its previous value. It never takes a value other than the old one or the qualified one.
- R4: `updateStrobe` is high for exactly the one cycle in which a newly qualified code appears on `acceptedCode`, and low in all other cycles.
- R5: A valid raw sample that differs from the current candidate restarts qualification from that sample, counting it as the first of the new run.
- R6: Cycles with `rawValid` low are not counted, do not restart qualification, and the raw code presented in them has no effect.
- R7: A candidate equal to the code already accepted (after the first acceptance) qualifies silently. It raises no strobe and leaves `acceptedCode` unchanged, including when the raw code returns to the accepted value after a partial run of another code.
- R8: `initValid` rises together with the first acceptance, even when the first code is 0 (so equal to the reset value of `acceptedCode`). That first acceptance raises the strobe. The flag then stays high until reset.
- R9: After the first acceptance the block keeps qualifying new codes, so any number of later changes are each applied under R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one raw sample per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rawCode | input | 4 | Code from the upstream converter |
| rawValid | input | 1 | High when `rawCode` holds a fresh sample |
| acceptedCode | output | 4 | Last qualified code |
| updateStrobe | output | 1 | One-cycle pulse when `acceptedCode` takes a new value |
| initValid | output | 1 | High once a first code has been accepted |

## Verification
The assertions make no assumption about `rawCode` in cycles where `rawValid` is low. They do assume that `rawValid` and `rawCode` are settled before each rising edge. The bench meets this by changing both only on falling edges. The assertions also take for granted that the stability counter starts a candidate at one and never passes that candidate's target, which bounds the window they check. The stimulus covers every corner of this window: the lowest and highest codes, a first code equal to the reset value, repeated codes, mid-run restarts, gaps in `rawValid` that carry a foreign code, and a return to the accepted code.

// File: rtl/settle_pkg.sv
package settle_pkg;

  // Strobes from the control block to the datapath, one cycle each.
  typedef struct packed {
    logic loadCand;   // take rawCode as new candidate, count restarts at 1
    logic advance;    // candidate seen again, bump stability count
    logic commit;     // candidate qualified and new: publish it
  } settleCtrl_t;

endpackage

// File: rtl/settle_control.sv
module settle_control
  import settle_pkg::*;
(
  input  logic        rawValid,
  input  logic        candMatch,
  input  logic        atLimit,
  input  logic        nearLimit,
  input  logic        candNew,
  output settleCtrl_t ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.loadCand = rawValid && !candMatch;
    ctrl.advance  = rawValid && candMatch && !atLimit;
    ctrl.commit   = rawValid && candMatch && !atLimit && nearLimit && candNew;
  end

endmodule

// File: rtl/settle_datapath.sv
module settle_datapath
  import settle_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int STEP   = 16,
  parameter int OFFSET = 6,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rawCode,
  input  settleCtrl_t       ctrl,
  output logic              candMatch,
  output logic              atLimit,
  output logic              nearLimit,
  output logic              candNew,
  output logic [CODE_W-1:0] acceptedCode,
  output logic              updateStrobe,
  output logic              initValid
);

  logic [CODE_W-1:0] candCode;
  logic              candValid;
  logic [CNT_W-1:0]  stableCnt;
  logic [CNT_W-1:0]  tgtCand;

  function automatic logic [CNT_W-1:0] targetOf(input logic [CODE_W-1:0] code);
    return CNT_W'(STEP) * (CNT_W'(code) + CNT_W'(OFFSET));
  endfunction

  assign tgtCand   = targetOf(candCode);
  assign candMatch = candValid && (rawCode == candCode);
  assign atLimit   = (stableCnt == tgtCand);
  assign nearLimit = (stableCnt == tgtCand - CNT_W'(1));
  assign candNew   = !initValid || (candCode != acceptedCode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      candCode  <= '0;
      candValid <= 1'b0;
      stableCnt <= '0;
    end else if (ctrl.loadCand) begin
      candCode  <= rawCode;
      candValid <= 1'b1;
      stableCnt <= CNT_W'(1);
    end else if (ctrl.advance) begin
      stableCnt <= stableCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acceptedCode <= '0;
      initValid    <= 1'b0;
      updateStrobe <= 1'b0;
    end else begin
      updateStrobe <= ctrl.commit;
      if (ctrl.commit) begin
        acceptedCode <= candCode;
        initValid    <= 1'b1;
      end
    end
  end

  // Stability count never runs past the current candidate's target.
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    candValid |-> (stableCnt <= tgtCand));

  // A published code had been seen exactly target times.
  assert_commit_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |-> ($past(stableCnt) == targetOf(acceptedCode) - CNT_W'(1)));

  // The accepted code only moves together with the strobe.
  assert_change_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acceptedCode != $past(acceptedCode)) |-> updateStrobe);

  // The strobe is a single-cycle pulse.
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |=> !updateStrobe);

  // The initial-valid flag is sticky and accompanies every strobe.
  assert_init_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    initValid |=> initValid);

  assert_strobe_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |-> initValid);

endmodule

// File: rtl/code_settle_filter.sv
module code_settle_filter
  import settle_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int STEP   = 16,
  parameter int OFFSET = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rawCode,
  input  logic              rawValid,
  output logic [CODE_W-1:0] acceptedCode,
  output logic              updateStrobe,
  output logic              initValid
);

  localparam int MAX_TGT = STEP * ((1 << CODE_W) - 1 + OFFSET);
  localparam int CNT_W   = $clog2(MAX_TGT + 1);

  settleCtrl_t ctrl;
  logic        candMatch;
  logic        atLimit;
  logic        nearLimit;
  logic        candNew;

  settle_control u_ctrl (
    .rawValid  (rawValid),
    .candMatch (candMatch),
    .atLimit   (atLimit),
    .nearLimit (nearLimit),
    .candNew   (candNew),
    .ctrl      (ctrl)
  );

  settle_datapath #(
    .CODE_W (CODE_W),
    .STEP   (STEP),
    .OFFSET (OFFSET),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .rawCode      (rawCode),
    .ctrl         (ctrl),
    .candMatch    (candMatch),
    .atLimit      (atLimit),
    .nearLimit    (nearLimit),
    .candNew      (candNew),
    .acceptedCode (acceptedCode),
    .updateStrobe (updateStrobe),
    .initValid    (initValid)
  );

  // Cycles without a valid sample leave the published outputs untouched.
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rawValid) |-> !updateStrobe);

endmodule

// File: tb/tb_code_settle_filter.sv
module tb_code_settle_filter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rawCode;
  logic       rawValid;
  logic [3:0] acceptedCode;
  logic       updateStrobe;
  logic       initValid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  code_settle_filter dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rawCode      (rawCode),
    .rawValid     (rawValid),
    .acceptedCode (acceptedCode),
    .updateStrobe (updateStrobe),
    .initValid    (initValid)
  );

  // {expect strobe, code}
  localparam logic [4:0] VEC [6] = '{
    {1'b1, 4'd0}, {1'b1, 4'd5}, {1'b0, 4'd5},
    {1'b1, 4'd15}, {1'b1, 4'd2}, {1'b1, 4'd9}
  };

  function automatic int tgt(input int k);
    return 16 * (k + 6);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a code for n cycles, counting strobes seen.
  task automatic drive(input logic [3:0] code, input logic vld, input int n,
                       output int strobes);
    strobes = 0;
    rawCode  = code;
    rawValid = vld;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (updateStrobe) strobes++;
    end
  endtask

  initial begin
    #(100000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s;
    int s2;
    rst_n = 1'b0; rawCode = 4'd7; rawValid = 1'b1;
    repeat (3) @(negedge clk);
    check(acceptedCode == 0 && !initValid && !updateStrobe, "R1",
          "reset outputs", {acceptedCode, initValid, updateStrobe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(acceptedCode == 0 && !initValid && !updateStrobe, "R1",
          "first cycle after reset", {acceptedCode, initValid, updateStrobe}, 0);

    // Table walk: R2, R3, R4, R7, R8, R9
    for (int e = 0; e < 6; e++) begin
      logic [3:0] prev;
      int n;
      prev = acceptedCode;
      n = tgt(int'(VEC[e][3:0]));
      drive(VEC[e][3:0], 1'b1, n - 1, s);
      check(acceptedCode == prev, "R3", "held before target", acceptedCode, prev);
      if (e == 0) check(!initValid, "R8", "no init before first accept", initValid, 0);
      drive(VEC[e][3:0], 1'b1, 1, s2);
      s += s2;
      check(acceptedCode == VEC[e][3:0], "R2", "accepted at target",
            acceptedCode, VEC[e][3:0]);
      check(updateStrobe == VEC[e][4], "R4", "strobe at target", updateStrobe, VEC[e][4]);
      drive(VEC[e][3:0], 1'b1, 1, s2);
      check(!updateStrobe, "R4", "strobe one cycle", updateStrobe, 0);
      check(s == int'(VEC[e][4]), "R7", "strobe count", s, VEC[e][4]);
      check(initValid, "R8", "init flag set", initValid, 1);
    end

    // R5: partial run of 3 then switch to 7 restarts qualification
    drive(4'd3, 1'b1, 50, s);
    drive(4'd7, 1'b1, tgt(7) - 1, s);
    check(acceptedCode == 9, "R5", "restart not yet done", acceptedCode, 9);
    drive(4'd7, 1'b1, 1, s);
    check(acceptedCode == 7 && updateStrobe, "R5", "accepted after restart",
          acceptedCode, 7);

    // R6: invalid gap carrying a foreign code
    drive(4'd1, 1'b1, 56, s);
    drive(4'd12, 1'b0, 30, s);
    check(acceptedCode == 7 && s == 0, "R6", "gap ignored", acceptedCode, 7);
    drive(4'd1, 1'b1, 55, s);
    check(acceptedCode == 7, "R6", "gap not counted", acceptedCode, 7);
    drive(4'd1, 1'b1, 1, s);
    check(acceptedCode == 1 && updateStrobe, "R6", "accepted across gap",
          acceptedCode, 1);

    // R7: partial run of 4, then back to accepted 1: silent
    drive(4'd4, 1'b1, 100, s);
    drive(4'd1, 1'b1, 200, s2);
    check(s + s2 == 0, "R7", "no strobe on return", s + s2, 0);
    check(acceptedCode == 1, "R7", "code unchanged", acceptedCode, 1);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(acceptedCode == 0 && !initValid && !updateStrobe, "R1",
          "mid-run reset", {acceptedCode, initValid, updateStrobe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!initValid, "R1", "init low after reset release", initValid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule